// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches one 16-bit word at a time from a three-wire serial EEPROM with a chip select, a serial clock, a data line into the memory and a data line out of it. The system pulses a request together with a 6-bit word address. The block then runs the whole access on the serial pins and raises a one-cycle done strobe. The fetched word is held on its output until the next read.

Every access has three stages. First comes an idle clocking stretch with the memory selected, which ends with the memory deselected. Next, inside one select window, the block sends a single wake pulse, shifts out the read command and clocks in the data. The access closes with a second idle clocking stretch.

The serial clock is slowed down from the system clock by a half-period divider. The divider is set by two parameters: the system clock frequency and the minimum time each serial clock level must last. The data line from the memory passes through a synchronizer before the block samples it.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is high, and in the cycle after it, ee_cs, ee_sk, ee_di, busy and done are all 0. This also applies when reset arrives in the middle of an access.
- R2: Within the main select window, the first rising ee_sk edge carries ee_di = 0 (the wake pulse). The next 11 rising edges carry the command MSB first: 0, 0, start bit 1, opcode 1 then 0, then the six address bits MSB first. As a number this is 0x180 OR address.
- R3: ee_di never changes while ee_sk stays high.
- R4: After the command, 16 more ee_sk pulses are given. On each pulse, ee_do is sampled at the end of the high level, MSB first. rd_data equals the memory word when done is high, and keeps that value afterwards.
- R5: Each access opens with a window in which ee_cs is high for exactly 26 ee_sk pulses. ee_sk then stays low and ee_cs drops for one half period before the main window.
- R6: The main window continues after the data bits with 26 more idle pulses (54 pulses in total), then ends with ee_sk low and ee_cs dropped.
- R7: Each ee_sk high level lasts exactly HALF_DIV system cycles, where HALF_DIV = ceil(CLK_MHZ*HALF_NS/1000). Each low level inside an access also lasts HALF_DIV cycles.
- R8: busy goes high in the cycle after an accepted request and falls in the cycle in which done rises. done is a one-cycle pulse. done arrives 164*HALF_DIV cycles after the edge that accepted the request.
- R9: A request made while busy is high starts no new access and does not change the address of the access in progress.
- R10: ee_sk is low whenever ee_cs is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Start a read; accepted only while idle |
| rd_addr | input | 6 | Word address, captured on acceptance |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle strobe: read finished |
| rd_data | output | 16 | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Serial clock to memory |
| ee_di | output | 1 | Serial data to memory |
| ee_do | input | 1 | Serial data from memory |

## Verification
The bench reads every one of the 64 addresses from a behavioural memory model. The model decodes the start bit, opcode and address itself and returns a word that is computed from the address. A wrong address or opcode bit therefore shows up as wrong data, and a bit-order or sampling-phase error shows up on almost every address.

For each read, the bench also records the serial traffic. It counts the pulses in each select window, which separates preamble errors from postamble errors. It captures the command bits, which locates any error in the command framing. It measures the high time of ee_sk and the request-to-done latency, which separate divider errors from sequencing errors.

Two further patterns are applied. A second request arrives in the middle of an access and must leave the returned word unchanged. A reset arrives in the middle of an access and must return the pins to their idle levels.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    // Idle clock pulses given before and after every access.
    localparam int unsigned IDLE_PULSES = 26;
    // Idle stretch: pulses, one low step with select high, one deselected step.
    localparam int unsigned IDLE_STEPS  = 2 * IDLE_PULSES + 2;
    // Start bit plus two opcode bits.
    localparam int unsigned HDR_BITS    = 3;
    // Leading zeros ahead of the start bit.
    localparam int unsigned LEAD_ZEROS  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_WAKE,
        PH_CMD,
        PH_DATA,
        PH_POST
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    // Read command: start bit 1, opcode 10, then the address.
    function automatic logic [31:0] read_cmd(input logic [31:0] addr, input int unsigned aw);
        return (32'd6 << aw) | addr;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ee_rd_divider.sv
module ee_rd_divider #(
    parameter int unsigned HALF_DIV = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ee_rd_sequencer.sv
module ee_rd_sequencer
    import ee_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic              sample,
    output pins_t             pins
);
    localparam int unsigned CMD_BITS  = LEAD_ZEROS + HDR_BITS + ADDR_W;
    localparam int unsigned MAX_STEPS = max3(IDLE_STEPS, 2 * CMD_BITS, 2 * DATA_W);
    localparam int unsigned SW        = $clog2(MAX_STEPS);
    localparam logic [SW-1:0] IDLE_LAST  = SW'(IDLE_STEPS - 1);
    localparam logic [SW-1:0] PULSE_END  = SW'(2 * IDLE_PULSES);
    localparam logic [SW-1:0] CMD_LAST   = SW'(2 * CMD_BITS - 1);
    localparam logic [SW-1:0] DATA_LAST  = SW'(2 * DATA_W - 1);

    phase_e              phase_q;
    logic [SW-1:0]       step_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic                done_q;
    logic [SW-1:0]       last_step;
    phase_e              phase_nx;

    always_comb begin
        unique case (phase_q)
            PH_PRE, PH_POST: last_step = IDLE_LAST;
            PH_WAKE:         last_step = SW'(1);
            PH_CMD:          last_step = CMD_LAST;
            PH_DATA:         last_step = DATA_LAST;
            default:         last_step = '0;
        endcase
    end

    always_comb begin
        unique case (phase_q)
            PH_PRE:  phase_nx = PH_WAKE;
            PH_WAKE: phase_nx = PH_CMD;
            PH_CMD:  phase_nx = PH_DATA;
            PH_DATA: phase_nx = PH_POST;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            cmd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (req) begin
                    phase_q <= PH_PRE;
                    step_q  <= '0;
                    cmd_q   <= CMD_BITS'(read_cmd(32'(addr), ADDR_W));
                end
            end else if (tick) begin
                if (step_q == last_step) begin
                    step_q  <= '0;
                    phase_q <= phase_nx;
                    if (phase_q == PH_POST) begin
                        done_q <= 1'b1;
                    end
                end else begin
                    step_q <= step_q + 1'b1;
                    if (phase_q == PH_CMD && step_q[0]) begin
                        cmd_q <= cmd_q << 1;
                    end
                end
            end
        end
    end

    // Pin decode from the registered phase and step.
    always_comb begin
        pins = '0;
        unique case (phase_q)
            PH_PRE, PH_POST: begin
                pins.cs = (step_q != IDLE_LAST);
                pins.sk = (step_q < PULSE_END) && step_q[0];
            end
            PH_WAKE, PH_DATA: begin
                pins.cs = 1'b1;
                pins.sk = step_q[0];
            end
            PH_CMD: begin
                pins.cs = 1'b1;
                pins.sk = step_q[0];
                pins.di = cmd_q[CMD_BITS-1];
            end
            default: pins = '0;
        endcase
    end

    assign busy   = (phase_q != PH_IDLE);
    assign done   = done_q;
    assign sample = tick && (phase_q == PH_DATA) && step_q[0];
endmodule

// File: rtl/ee_rd_capture.sv
module ee_rd_capture #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              sample,
    output logic [DATA_W-1:0] word
);
    logic [SYNC_STAGES:0] sync_q;
    logic [DATA_W-1:0]    word_q;

    assign sync_q[0] = din;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[s+1] <= 1'b0;
            end else begin
                sync_q[s+1] <= sync_q[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (sample) begin
            word_q <= {word_q[DATA_W-2:0], sync_q[SYNC_STAGES]};
        end
    end

    assign word = word_q;
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
    import ee_rd_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 125,
    parameter int unsigned HALF_NS     = 2000,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int unsigned HALF_RAW = (CLK_MHZ * HALF_NS + 999) / 1000;
    localparam int unsigned HALF_DIV = (HALF_RAW > SYNC_STAGES + 1) ? HALF_RAW : SYNC_STAGES + 1;

    logic  tick;
    logic  sample;
    pins_t pins;

    ee_rd_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    ee_rd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (rd_req),
        .addr   (rd_addr),
        .tick   (tick),
        .busy   (busy),
        .done   (done),
        .sample (sample),
        .pins   (pins)
    );

    ee_rd_capture #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .din    (ee_do),
        .sample (sample),
        .word   (rd_data)
    );

    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk #(
    parameter int unsigned HALF_DIV = 250
) (
    input logic clk,
    input logic rst,
    input logic req,
    input logic busy,
    input logic done,
    input logic cs,
    input logic sk,
    input logic di
);
    logic [31:0] hi_cnt;
    logic        sk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            sk_q   <= 1'b0;
        end else begin
            sk_q   <= sk;
            hi_cnt <= sk ? hi_cnt + 1 : 32'd0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!cs && !sk && !di && !busy && !done));

    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sk) && sk) |-> (di == $past(di)));

    // R10
    sk_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !sk);

    // R7
    sk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (sk_q && !sk) |-> (hi_cnt == HALF_DIV));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);
endmodule

bind ee_word_reader ee_word_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (rd_req),
    .busy (busy),
    .done (done),
    .cs   (ee_cs),
    .sk   (ee_sk),
    .di   (ee_di)
);

// File: tb/ee_word_reader_bench.sv
`timescale 1ns/1ps
module ee_word_reader_bench;
    localparam int CLK_MHZ = 125;
    localparam int HALF_NS = 32;
    localparam int H       = (CLK_MHZ * HALF_NS + 999) / 1000;
    localparam int STEPS   = 2 * (2 * 26 + 2) + 2 + 2 * 11 + 2 * 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        busy, done, ee_cs, ee_sk, ee_di;
    logic [15:0] rd_data;
    logic        m_do = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    ee_word_reader #(.CLK_MHZ(CLK_MHZ), .HALF_NS(HALF_NS)) u_ee_word_reader (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .done(done), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(m_do)
    );

    function automatic logic [15:0] mem_word(input int a);
        return 16'(a * 40503) ^ 16'h5A3C ^ 16'(a << 9);
    endfunction

    // Memory model: waits for a start bit, takes opcode and address, returns data.
    int         m_st = 0, m_cnt = 0, m_bit = 0;
    logic [7:0] m_hdr = '0;
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            m_st = 0; m_cnt = 0; m_do = 1'b0;
        end else begin
            case (m_st)
                0: if (ee_di) begin m_st = 1; m_cnt = 0; m_hdr = '0; end
                1: begin
                    m_hdr = {m_hdr[6:0], ee_di};
                    m_cnt++;
                    if (m_cnt == 8) begin m_st = 2; m_bit = 15; end
                end
                2: begin
                    logic [15:0] w;
                    w = mem_word(int'(m_hdr[5:0]));
                    m_do = (m_hdr[7:6] == 2'b10) ? w[m_bit] : 1'b0;
                    m_bit--;
                    if (m_bit < 0) m_st = 3;
                end
                default: ;
            endcase
        end
    end

    // Window monitor: pulses per select window and first 12 data-in bits.
    int          w_cnt = 0, w_last = 0, w_prev = 0;
    logic [11:0] w_bits = '0, w_bits_last = '0;
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            w_prev = w_last; w_last = w_cnt; w_bits_last = w_bits;
            w_cnt = 0; w_bits = '0;
        end else begin
            if (w_cnt < 12) w_bits = {w_bits[10:0], ee_di};
            w_cnt++;
        end
    end

    // High-time monitor.
    int hi_run = 0, hi_last = 0;
    always @(negedge clk) begin
        if (ee_sk === 1'b1) hi_run++;
        else begin
            if (hi_run != 0) hi_last = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic wait_done(output int n);
        n = 0;
        while (done !== 1'b1 && n < 4 * STEPS * H) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_read(input int a, input bit full);
        int n;
        @(negedge clk);
        rd_addr = 6'(a); rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        if (full) chk(busy === 1'b1, "R8 busy after accept", busy, 1);
        wait_done(n);
        chk(rd_data === mem_word(a), "R4 data", rd_data, mem_word(a));
        chk(w_bits_last === (12'h180 | 12'(a)), "R2 command bits", w_bits_last, 12'h180 | 12'(a));
        chk(w_prev == 26, "R5 preamble pulses", w_prev, 26);
        chk(w_last == 54, "R6 main window pulses", w_last, 54);
        if (full) begin
            chk(n == STEPS * H, "R8 latency", n, STEPS * H);
            chk(hi_last == H, "R7 sk high time", hi_last, H);
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b0, "R8 done pulse width", {done, busy}, 0);
            chk(rd_data === mem_word(a), "R4 data held", rd_data, mem_word(a));
        end
    endtask

    initial begin
        int n;
        int seen;
        repeat (5) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done} === 5'b0, "R1 reset outputs", {ee_cs, ee_sk, ee_di, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done} === 5'b0, "R1 idle after reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);

        // Exhaustive address sweep.
        for (int a = 0; a < 64; a++) do_read(a, (a % 8) == 0 || a == 63);

        // R9: a request during an access is ignored.
        @(negedge clk);
        rd_addr = 6'd5; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (100) @(negedge clk);
        rd_addr = 6'd40; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(busy === 1'b1, "R9 still busy", busy, 1);
        wait_done(n);
        chk(rd_data === mem_word(5), "R9 data from first address", rd_data, mem_word(5));
        chk(w_bits_last === 12'h185, "R9 command unchanged", w_bits_last, 12'h185);
        seen = 0;
        repeat (1000) begin
            @(negedge clk);
            if (busy === 1'b1 || done === 1'b1 || ee_cs === 1'b1) seen++;
        end
        chk(seen == 0, "R9 no second access", seen, 0);

        // R1: reset in the middle of an access.
        @(negedge clk);
        rd_addr = 6'd17; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (300) @(negedge clk);
        chk(ee_cs === 1'b1, "R1 mid-access select", ee_cs, 1);
        rst = 1'b1;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done} === 5'b0, "R1 reset mid-access", {ee_cs, ee_sk, ee_di, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        do_read(42, 1'b1);

        finish_run();
    end
endmodule